// File: doc/BRIEF.md
# Cluster Coherency Control Register File

A small memory-mapped register block for a multiprocessor cluster. It sits in a 256-byte window behind a simple register bus with separate read and write strobes, an 8-bit byte offset, a transfer size given as a byte count and 32-bit write data. It holds a one-bit coherency enable and a 32-bit power-status word with one byte per core. It also presents a read-only configuration word computed from the core-count parameter.

The power-status word can be reached at four consecutive byte offsets. Narrow writes there update only the selected lanes. Reads there return the word shifted down to the lane addressed. A handful of offsets read as zero and ignore writes: address filtering, access control and a cache-invalidate command with nothing to invalidate. Any other offset behaves the same way. A write with an unsupported size is rejected and flagged for one cycle.

Top module: `ccr_regfile`

## Requirements
- R1: After reset, `ctrl_en_o`, `pwr_state_o`, `rdata_o` and `err_o` are all zero.
- R2: A valid-size write at offset 0x00 stores `wdata_i[0]` as the enable bit. A read at 0x00 returns that bit in bit 0, with the other bits zero.
- R3: A read at offset 0x04 returns `((1 << NUM_CORES) - 1) << 4 | (NUM_CORES - 1)`. Writes at 0x04 change nothing.
- R4: A read at offset 0x08+k, with k from 0 to 3, returns the power-status word shifted right by 8*k bits.
- R5: A valid write at 0x08+k replaces only the bits of the size mask shifted left by 8*k; bits shifted past bit 31 are dropped. The size mask is 0xFF, 0xFFFF or 0xFFFFFFFF. All other power-status bits keep their value.
- R6: `size_i` gives the byte count: 1, 2 and 4 are valid. Any other value on a write raises `err_o` for exactly the following cycle and changes no register.
- R7: A write at offset 0x0C is accepted without error and changes no state.
- R8: Offsets 0x40, 0x44, 0x50, 0x54 and every other offset not listed above read as zero. Valid-size writes to them change no state and raise no error.
- R9: Read data is registered: `rdata_o` shows the addressed value one clock after the read strobe and holds while no read is issued. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset within the window |
| size_i | input | 3 | Write size in bytes (1, 2 or 4 valid) |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle flag for a write with an unsupported size |
| ctrl_en_o | output | 1 | Coherency enable bit |
| pwr_state_o | output | 32 | Power-status word, one byte per core |

## Verification
On every cycle the assertions check several properties. The power-status word and the enable bit move only in response to a write. A rejected write always raises the flag and leaves both registers alone, and the flag never appears without a write behind it. Read data holds between reads. The configuration, filter and access-control offsets always read back the expected constant. Only the directed scenarios can show the exact lane arithmetic of narrow and shifted writes, the shifted readback at each byte offset, and the old-value result of a read that collides with a write.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SIZE_W = 3;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_CFG   = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_PWR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_INV   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FLT_S = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_FLT_E = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_ACC_S = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_ACC_N = 8'h54;

  function automatic logic [DATA_W-1:0] cfg_word(input int unsigned n);
    logic [DATA_W-1:0] m;
    m = ((DATA_W'(1) << n) - DATA_W'(1)) << 4;
    return m | DATA_W'(n - 1);
  endfunction

  // valid flag plus lane mask for a byte-count size
  function automatic logic [DATA_W:0] size_mask(input logic [SIZE_W-1:0] sz);
    case (sz)
      3'd1:    return {1'b1, 32'h0000_00FF};
      3'd2:    return {1'b1, 32'h0000_FFFF};
      3'd4:    return {1'b1, 32'hFFFF_FFFF};
      default: return {1'b0, 32'h0000_0000};
    endcase
  endfunction
endpackage

// File: rtl/ccr_wdec.sv
module ccr_wdec
  import ccr_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ctrl_we_o,
  output logic              pwr_we_o,
  output logic [DATA_W-1:0] pwr_mask_o,
  output logic [DATA_W-1:0] pwr_val_o,
  output logic              bad_size_o
);
  logic [DATA_W:0]   sm;
  logic              ok;
  logic [DATA_W-1:0] mask;
  logic [4:0]        sh;

  always_comb begin
    sm   = size_mask(size_i);
    ok   = sm[DATA_W];
    mask = sm[DATA_W-1:0];
    sh   = {addr_i[1:0], 3'b000};
    ctrl_we_o  = wr_en_i && ok && (addr_i == OFF_CTRL);
    pwr_we_o   = wr_en_i && ok && (addr_i[ADDR_W-1:2] == OFF_PWR[ADDR_W-1:2]);
    pwr_mask_o = mask << sh;
    pwr_val_o  = (wdata_i & mask) << sh;
    bad_size_o = wr_en_i && !ok;
  end
endmodule

// File: rtl/ccr_pwr_word.sv
module ccr_pwr_word #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] mask_i,
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~mask_i) | (val_i & mask_i);
  end

  AST_PWR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
  import ccr_pkg::*;
#(
  parameter logic [DATA_W-1:0] CFG = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ctrl_i,
  input  logic [DATA_W-1:0] pwr_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (addr_i == OFF_CTRL)
      data_o = {{(DATA_W-1){1'b0}}, ctrl_i};
    else if (addr_i == OFF_CFG)
      data_o = CFG;
    else if (addr_i[ADDR_W-1:2] == OFF_PWR[ADDR_W-1:2])
      data_o = pwr_i >> {addr_i[1:0], 3'b000};
    // invalidate, filter, access-control and unknown offsets read zero
  end
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int unsigned NUM_CORES = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              ctrl_en_o,
  output logic [DATA_W-1:0] pwr_state_o
);
  localparam logic [DATA_W-1:0] CFG_WORD = cfg_word(NUM_CORES);

  logic              ctrl_we, pwr_we, bad_size;
  logic [DATA_W-1:0] pwr_mask, pwr_val, rd_val;

  ccr_wdec u_wdec (
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .size_i    (size_i),
    .wdata_i   (wdata_i),
    .ctrl_we_o (ctrl_we),
    .pwr_we_o  (pwr_we),
    .pwr_mask_o(pwr_mask),
    .pwr_val_o (pwr_val),
    .bad_size_o(bad_size)
  );

  ccr_pwr_word #(.WIDTH(DATA_W)) u_pwr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (pwr_we),
    .mask_i(pwr_mask),
    .val_i (pwr_val),
    .q_o   (pwr_state_o)
  );

  ccr_rdmux #(.CFG(CFG_WORD)) u_rdmux (
    .addr_i(addr_i),
    .ctrl_i(ctrl_en_o),
    .pwr_i (pwr_state_o),
    .data_o(rd_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_o <= 1'b0;
      err_o     <= 1'b0;
      rdata_o   <= '0;
    end else begin
      if (ctrl_we) ctrl_en_o <= wdata_i[0];
      err_o <= bad_size;
      if (rd_en_i) rdata_o <= rd_val;
    end
  end

  AST_CTRL_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_en_o) |-> $past(wr_en_i && addr_i == OFF_CTRL)); // R2
  AST_CFG_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == OFF_CFG) |=> rdata_o == CFG_WORD); // R3
  AST_BAD_SIZE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !(size_i == 3'd1 || size_i == 3'd2 || size_i == 3'd4))
    |=> err_o && $stable(pwr_state_o) && $stable(ctrl_en_o)); // R6
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i)); // R6
  AST_RAZ_OFFSETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && (addr_i == OFF_FLT_S || addr_i == OFF_FLT_E ||
                 addr_i == OFF_ACC_S || addr_i == OFF_ACC_N || addr_i == OFF_INV))
    |=> rdata_o == '0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R9
endmodule

// File: tb/ccr_regfile_test.sv
`timescale 1ns/1ps
module ccr_regfile_test;
  localparam int unsigned N = 4;
  localparam logic [31:0] CFG_EXP = (((32'd1 << N) - 32'd1) << 4) | (N - 1);

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [2:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, pwr_state_o;
  logic        err_o, ctrl_en_o;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ccr_regfile #(.NUM_CORES(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .err_o(err_o), .ctrl_en_o(ctrl_en_o), .pwr_state_o(pwr_state_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; size_i = sz; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset;
    chk("R1 ctrl", {31'b0, ctrl_en_o}, 0);
    chk("R1 pwr", pwr_state_o, 0);
    chk("R1 rdata", rdata_o, 0);
    chk("R1 err", {31'b0, err_o}, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(8'h00, 3'd1, 32'hFFFF_FFFF);
    chk("R2 ctrl set", {31'b0, ctrl_en_o}, 1);
    rd(8'h00, d);
    chk("R2 ctrl read", d, 32'h1);
    wr(8'h00, 3'd4, 32'hFFFF_FFFE);
    chk("R2 ctrl clear", {31'b0, ctrl_en_o}, 0);
  endtask

  task automatic t_cfg;
    logic [31:0] d;
    rd(8'h04, d);
    chk("R3 cfg read", d, CFG_EXP);
    wr(8'h04, 3'd4, 32'h0);
    rd(8'h04, d);
    chk("R3 cfg after write", d, CFG_EXP);
    chk("R3 no side effect", pwr_state_o, 0);
  endtask

  task automatic t_pwr;
    logic [31:0] d;
    wr(8'h0A, 3'd1, 32'h1234_56AB);
    chk("R5 byte lane 2", pwr_state_o, 32'h00AB_0000);
    wr(8'h0B, 3'd2, 32'h0000_1234);
    chk("R5 half at 0x0B truncated", pwr_state_o, 32'h34AB_0000);
    wr(8'h08, 3'd4, 32'hDEAD_BEEF);
    chk("R5 full word", pwr_state_o, 32'hDEAD_BEEF);
    wr(8'h09, 3'd2, 32'h0000_0000);
    chk("R5 half at 0x09", pwr_state_o, 32'hDE00_00EF);
    rd(8'h08, d); chk("R4 read 0x08", d, 32'hDE00_00EF);
    rd(8'h09, d); chk("R4 read 0x09", d, 32'h00DE_0000);
    rd(8'h0A, d); chk("R4 read 0x0A", d, 32'h0000_DE00);
    rd(8'h0B, d); chk("R4 read 0x0B", d, 32'h0000_00DE);
    wr(8'h0A, 3'd4, 32'h1122_3344);
    chk("R5 word at 0x0A", pwr_state_o, 32'h3344_00EF);
  endtask

  task automatic t_bad_size;
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 8'h08; size_i = 3'd3; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk("R6 err raised", {31'b0, err_o}, 1);
    chk("R6 pwr unchanged", pwr_state_o, 32'h3344_00EF);
    @(negedge clk);
    chk("R6 err one cycle", {31'b0, err_o}, 0);
    wr(8'h00, 3'd0, 32'h1);
    chk("R6 ctrl unchanged size0", {31'b0, ctrl_en_o}, 0);
    wr(8'h08, 3'd1, 32'h0);
    chk("R6 no err on valid size", {31'b0, err_o}, 0);
  endtask

  task automatic t_invalidate;
    logic [31:0] d;
    wr(8'h0C, 3'd4, 32'hFFFF_FFFF);
    chk("R7 no err", {31'b0, err_o}, 0);
    chk("R7 pwr kept", pwr_state_o, 32'h3344_0000);
    chk("R7 ctrl kept", {31'b0, ctrl_en_o}, 0);
    rd(8'h0C, d);
    chk("R7 reads zero", d, 0);
  endtask

  task automatic t_raz;
    logic [31:0] d;
    logic [7:0] offs [6] = '{8'h40, 8'h44, 8'h50, 8'h54, 8'h01, 8'hFC};
    for (int i = 0; i < 6; i++) begin
      wr(offs[i], 3'd4, 32'hFFFF_FFFF);
      chk("R8 no err", {31'b0, err_o}, 0);
      rd(offs[i], d);
      chk("R8 read zero", d, 0);
    end
    chk("R8 pwr kept", pwr_state_o, 32'h3344_0000);
    chk("R8 ctrl kept", {31'b0, ctrl_en_o}, 0);
  endtask

  task automatic t_rd_timing;
    logic [31:0] d;
    @(negedge clk);
    wr_en_i = 1'b1; rd_en_i = 1'b1; addr_i = 8'h00; size_i = 3'd1; wdata_i = 32'h1;
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    chk("R9 collision old value", rdata_o, 0);
    chk("R9 write landed", {31'b0, ctrl_en_o}, 1);
    addr_i = 8'h04;
    @(negedge clk);
    chk("R9 hold without strobe", rdata_o, 0);
    rd(8'h00, d);
    chk("R9 new value", d, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_ctrl();
    t_cfg();
    t_pwr();
    t_bad_size();
    t_invalidate();
    t_raz();
    t_rd_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule